// File: doc/BRIEF.md
# Challenge Sweep Controller Register File

This block is the host-facing control plane of a signature generator. A host on a plain parallel byte bus (address, write data, write strobe, combinational read data) programs a control byte, a single challenge, a window exponent, a sweep length and a 64-bit host vector. A start command then makes the block step an external comparison datapath through one challenge, or through every challenge from 0 up to the sweep length minus one. Each challenge is held for a window of 2^E clock cycles.

At the last cycle of each window the block samples the datapath's result bit, optionally folds in the matching bit of the host vector, and stores it at the bit of the 64-bit response selected by the challenge. When the run ends it raises a sticky done flag and, if enabled, a sticky interrupt flag. Both are cleared by writing ones to a dedicated clear address. Busy, done and interrupt appear on their own pins, and the low response byte is mirrored on an 8-bit output.

Top module: `sweep_regfile`

## Requirements
- R1: After reset the control, challenge and cycle registers read 0, the sweep length reads 64, status, index and every response byte read 0, and the busy, done, irq and low-response outputs are 0.
- R2: Control register 0x00 holds global enable in bit 0, vector-fold enable in bit 3 and interrupt enable in bit 7. These read back. Start (bit 1) and response clear (bit 4) are self-clearing and always read 0. The other bits read 0.
- R3: A write to 0x00 starts a run only if bits 0 and 1 are both set in that write and the block is idle. Any other write, including one made while busy, leaves the run state unchanged.
- R4: In single mode the run uses the challenge in 0x01 (bits [5:0]). Busy rises on the clock edge that takes the start write and falls, with done set, exactly 2^E edges later.
- R5: Register 0x02 holds the exponent in bits [3:0] and sweep mode in bit 4, and reads back as written. The effective exponent is limited to the range 4 to 12.
- R6: In sweep mode challenges 0, 1, … , L-1 each take one window, back to back, where L comes from register 0x03 (bits [6:0]). A value of 0 acts as 1 and values above 64 act as 64. Address 0x1F reads the current challenge, which holds its last value after the run.
- R7: At the end of each window, response bit c receives genBit XOR (fold enable AND vector bit c), where c is the current challenge. All other response bits keep their values.
- R8: The response reads at 0x04..0x0B, least significant byte at 0x04, and ignores writes. The host vector is read/write at 0x0C..0x13 in the same byte order.
- R9: The irq flag is set together with done only when the interrupt enable bit is 1 at the end of the run.
- R10: A write to 0x20 clears done if bit 6 is set and clears irq if bit 5 is set. Each flag is cleared independently.
- R11: A control write with bit 4 set zeroes the whole response on that clock edge. This takes priority over a bit stored on the same edge.
- R12: Status at 0x1E shows busy in bit 7, done in bit 6 and irq in bit 5. The busy, done and irq pins follow those flags, and the low-response output equals response bits [7:0].
- R13: genChallenge carries the current challenge throughout each window, and genClear is high exactly in the first cycle of each window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Byte register address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe, one byte per cycle |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| genBit | input | 1 | Comparison result from the response datapath |
| genChallenge | output | 6 | Challenge being evaluated |
| genClear | output | 1 | First cycle of a window; datapath restarts its counters |
| busyO | output | 1 | Run in progress |
| doneO | output | 1 | Sticky run-complete flag |
| irqO | output | 1 | Sticky interrupt flag |
| respLowO | output | 8 | Live copy of response bits [7:0] |

## Verification
The bench counts the cycles from the start write to the done edge for one window, a short sweep and a full sweep. A window-length or clamp error would move done early or late by a whole number of windows. It makes start attempts with enable clear and in the middle of a run. A design that honoured either attempt would restart at challenge 0 and stretch the run. It compares every response bit against the per-challenge reference with vector folding on and off. An off-by-one in the sweep bound would leave bit L-1 unwritten or overwrite bit L. It clears done and irq one at a time. A shared clear would drop both flags at once.

// File: rtl/sweep_regfile_pkg.sv
package sweep_regfile_pkg;
  localparam int RESP_W = 64;
  localparam int CHAL_W = $clog2(RESP_W);
  localparam int EXP_W  = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic              latch;
    logic              finish;
    logic [CHAL_W-1:0] idx;
  } ctlStrobe_t;

  // datapath -> control configuration
  typedef struct packed {
    logic              startGo;
    logic              sweep;
    logic [EXP_W-1:0]  cycExp;
    logic [CHAL_W:0]   chalMax;
    logic [CHAL_W-1:0] chal;
  } runCfg_t;
endpackage

// File: rtl/sweep_regfile_regs.sv
module sweep_regfile_regs
  import sweep_regfile_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busWe,
  output logic [7:0]        busRdata,
  input  ctlStrobe_t        strobe,
  input  logic              genBit,
  input  logic              busy,
  input  logic [CHAL_W-1:0] curIdx,
  output runCfg_t           cfg,
  output logic              doneO,
  output logic              irqO,
  output logic [7:0]        respLowO
);
  localparam int NBYTE  = RESP_W / 8;
  localparam int BSEL_W = $clog2(NBYTE);
  localparam int VEC_BASE = 4 + NBYTE;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CHAL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CYC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MAX  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RESP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] A_VEND = ADDR_W'(VEC_BASE + NBYTE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(30);
  localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(31);
  localparam logic [ADDR_W-1:0] A_W1C  = ADDR_W'(32);

  logic              globalEn, memXorEn, irqEn;
  logic [CHAL_W-1:0] chalReg;
  logic [4:0]        cycReg;
  logic [CHAL_W:0]   maxReg;
  logic [RESP_W-1:0] resp;
  logic [RESP_W-1:0] vec;
  logic [7:0]        vecByte [NBYTE];
  logic              doneFlag, irqFlag;
  logic              wrCtrl, wrW1c, clearReq;
  logic [ADDR_W-1:0] respOff, vecOff;

  assign wrCtrl   = busWe && (busAddr == A_CTRL);
  assign wrW1c    = busWe && (busAddr == A_W1C);
  assign clearReq = wrCtrl && busWdata[4];

  assign cfg.startGo = wrCtrl && busWdata[1] && busWdata[0] && !busy;
  assign cfg.sweep   = cycReg[4];
  assign cfg.cycExp  = cycReg[EXP_W-1:0];
  assign cfg.chalMax = maxReg;
  assign cfg.chal    = chalReg;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      memXorEn <= 1'b0;
      irqEn    <= 1'b0;
      chalReg  <= '0;
      cycReg   <= '0;
      maxReg   <= (CHAL_W+1)'(RESP_W);
    end else if (busWe) begin
      if (busAddr == A_CTRL) begin
        globalEn <= busWdata[0];
        memXorEn <= busWdata[3];
        irqEn    <= busWdata[7];
      end
      if (busAddr == A_CHAL) chalReg <= busWdata[CHAL_W-1:0];
      if (busAddr == A_CYC)  cycReg  <= busWdata[4:0];
      if (busAddr == A_MAX)  maxReg  <= busWdata[CHAL_W:0];
    end
  end

  // host vector, one register per byte
  for (genvar g = 0; g < NBYTE; g++) begin : gVec
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        vecByte[g] <= '0;
      else if (busWe && busAddr == ADDR_W'(VEC_BASE + g))
        vecByte[g] <= busWdata;
    end
    assign vec[g*8 +: 8] = vecByte[g];
  end

  // response store: clear wins over a bit latched on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      resp <= '0;
    else if (clearReq)
      resp <= '0;
    else if (strobe.latch)
      resp[strobe.idx] <= genBit ^ (memXorEn & vec[strobe.idx]);
  end

  // sticky flags: a set on the same edge wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      if (strobe.finish)              doneFlag <= 1'b1;
      else if (wrW1c && busWdata[6])  doneFlag <= 1'b0;
      if (strobe.finish && irqEn)     irqFlag  <= 1'b1;
      else if (wrW1c && busWdata[5])  irqFlag  <= 1'b0;
    end
  end

  assign respOff = busAddr - A_RESP;
  assign vecOff  = busAddr - A_VEC;

  always_comb begin
    busRdata = '0;
    if (busAddr == A_CTRL)
      busRdata = {irqEn, 3'b000, memXorEn, 2'b00, globalEn};
    else if (busAddr == A_CHAL)
      busRdata = 8'(chalReg);
    else if (busAddr == A_CYC)
      busRdata = 8'(cycReg);
    else if (busAddr == A_MAX)
      busRdata = 8'(maxReg);
    else if (busAddr >= A_RESP && busAddr < A_VEC)
      busRdata = resp[{respOff[BSEL_W-1:0], 3'b000} +: 8];
    else if (busAddr >= A_VEC && busAddr < A_VEND)
      busRdata = vec[{vecOff[BSEL_W-1:0], 3'b000} +: 8];
    else if (busAddr == A_STAT)
      busRdata = {busy, doneFlag, irqFlag, 5'b00000};
    else if (busAddr == A_IDX)
      busRdata = 8'(curIdx);
  end

  assign doneO    = doneFlag;
  assign irqO     = irqFlag;
  assign respLowO = resp[7:0];

  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (resp == '0));
  // R10
  done_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(strobe.finish));
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(strobe.finish && irqEn));
  // R7
  keep_other_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latch && !clearReq |=> $stable(resp));
endmodule

// File: rtl/sweep_regfile_ctrl.sv
module sweep_regfile_ctrl
  import sweep_regfile_pkg::*;
#(
  parameter int EXP_MIN = 4,
  parameter int EXP_MAX = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  runCfg_t           cfg,
  output ctlStrobe_t        strobe,
  output logic              busy,
  output logic [CHAL_W-1:0] curIdx,
  output logic [CHAL_W-1:0] genChallenge,
  output logic              genClear
);
  localparam int CNT_W = EXP_MAX;

  logic [CNT_W-1:0]  winCnt;
  logic [CNT_W-1:0]  winEnd;
  logic [EXP_W-1:0]  expSnap;
  logic [EXP_W-1:0]  effExp;
  logic [CHAL_W:0]   effCount;
  logic [CHAL_W-1:0] lastIdx;
  logic              winLast;

  // clamp exponent and sweep length at start
  always_comb begin
    if (cfg.cycExp < EXP_W'(EXP_MIN))      effExp = EXP_W'(EXP_MIN);
    else if (cfg.cycExp > EXP_W'(EXP_MAX)) effExp = EXP_W'(EXP_MAX);
    else                                    effExp = cfg.cycExp;
    if (cfg.chalMax == '0)                         effCount = (CHAL_W+1)'(1);
    else if (cfg.chalMax > (CHAL_W+1)'(RESP_W))    effCount = (CHAL_W+1)'(RESP_W);
    else                                           effCount = cfg.chalMax;
  end

  assign winEnd  = CNT_W'((1 << expSnap) - 1);
  assign winLast = busy && (winCnt == winEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      curIdx  <= '0;
      lastIdx <= '0;
      winCnt  <= '0;
      expSnap <= EXP_W'(EXP_MIN);
    end else if (!busy) begin
      if (cfg.startGo) begin
        busy    <= 1'b1;
        winCnt  <= '0;
        expSnap <= effExp;
        curIdx  <= cfg.sweep ? '0 : cfg.chal;
        lastIdx <= cfg.sweep ? CHAL_W'(effCount - 1'b1) : cfg.chal;
      end
    end else if (winLast) begin
      winCnt <= '0;
      if (curIdx == lastIdx) busy   <= 1'b0;
      else                   curIdx <= curIdx + 1'b1;
    end else begin
      winCnt <= winCnt + 1'b1;
    end
  end

  assign strobe.latch  = winLast;
  assign strobe.finish = winLast && (curIdx == lastIdx);
  assign strobe.idx    = curIdx;
  assign genChallenge  = curIdx;
  assign genClear      = busy && (winCnt == '0);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !cfg.startGo |=> !busy);
  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strobe.finish));
  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch && !strobe.finish |=> curIdx == $past(curIdx) + 1'b1);
  // R13
  first_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> genClear);
endmodule

// File: rtl/sweep_regfile.sv
module sweep_regfile
  import sweep_regfile_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int EXP_MIN = 4,
  parameter int EXP_MAX = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busWe,
  output logic [7:0]        busRdata,
  input  logic              genBit,
  output logic [CHAL_W-1:0] genChallenge,
  output logic              genClear,
  output logic              busyO,
  output logic              doneO,
  output logic              irqO,
  output logic [7:0]        respLowO
);
  ctlStrobe_t        strobe;
  runCfg_t           cfg;
  logic              busy;
  logic [CHAL_W-1:0] curIdx;

  sweep_regfile_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRdata(busRdata),
    .strobe(strobe), .genBit(genBit), .busy(busy), .curIdx(curIdx),
    .cfg(cfg), .doneO(doneO), .irqO(irqO), .respLowO(respLowO)
  );

  sweep_regfile_ctrl #(.EXP_MIN(EXP_MIN), .EXP_MAX(EXP_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe),
    .busy(busy), .curIdx(curIdx),
    .genChallenge(genChallenge), .genClear(genClear)
  );

  assign busyO = busy;
endmodule

// File: tb/sweep_regfile_tb.sv
`timescale 1ns/1ps
module sweep_regfile_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWe = 1'b0;
  logic [7:0] busRdata;
  logic       genBit;
  logic [5:0] genChallenge;
  logic       genClear;
  logic       busyO, doneO, irqO;
  logic [7:0] respLowO;

  int total = 0;
  int bad = 0;
  logic [63:0] expResp = '0;

  always #4 clk = ~clk;

  function automatic logic refBit(input logic [5:0] c);
    return (^(c & 6'h2B)) ^ (c[0] & c[4]);
  endfunction

  assign genBit = refBit(genChallenge);

  sweep_regfile u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRdata(busRdata), .genBit(genBit), .genChallenge(genChallenge),
    .genClear(genClear), .busyO(busyO), .doneO(doneO), .irqO(irqO), .respLowO(respLowO)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic readResp(output logic [63:0] r);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      rd(6'(4 + i), b);
      r[i*8 +: 8] = b;
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // check done timing n cycles after a start write
  task automatic waitDone(input int n, input string tag);
    waitCycles(n - 1);
    chk({tag, " busy before end"}, busyO, 1);
    chk({tag, " done before end"}, doneO, 0);
    waitCycles(1);
    chk({tag, " busy after end"}, busyO, 0);
    chk({tag, " done at end"}, doneO, 1);
  endtask

  task automatic testReset();
    logic [7:0] b;
    logic [63:0] r;
    rd(6'h00, b); chk("R1 ctrl", b, 0);
    rd(6'h01, b); chk("R1 chal", b, 0);
    rd(6'h02, b); chk("R1 cyc", b, 0);
    rd(6'h03, b); chk("R1 max", b, 64);
    rd(6'h1E, b); chk("R1 status", b, 0);
    rd(6'h1F, b); chk("R1 index", b, 0);
    readResp(r);  chk("R1 resp", r, 0);
    chk("R1 pins", {busyO, doneO, irqO, respLowO}, 0);
  endtask

  task automatic testRegs();
    logic [7:0] b;
    wr(6'h00, 8'h89); rd(6'h00, b); chk("R2 ctrl readback", b, 8'h89);
    wr(6'h00, 8'hFC); rd(6'h00, b); chk("R2 self-clear bits", b, 8'h88);
    chk("R3 no start without enable", busyO, 0);
    wr(6'h00, 8'h01);
    wr(6'h01, 8'h2A); rd(6'h01, b); chk("R4 chal readback", b, 8'h2A);
    wr(6'h02, 8'h1F); rd(6'h02, b); chk("R5 cyc readback", b, 8'h1F);
    wr(6'h0C, 8'hA5); rd(6'h0C, b); chk("R8 vec low byte", b, 8'hA5);
    wr(6'h13, 8'h3C); rd(6'h13, b); chk("R8 vec high byte", b, 8'h3C);
    wr(6'h04, 8'hFF); rd(6'h04, b); chk("R8 resp write ignored", b, 0);
    wr(6'h0C, 8'h00); wr(6'h13, 8'h00);
  endtask

  task automatic testNoStart();
    wr(6'h00, 8'h02);
    chk("R3 start w/o enable busy", busyO, 0);
    waitCycles(2);
    chk("R3 start w/o enable later", busyO, 0);
  endtask

  task automatic testSingle();
    logic [7:0] b;
    logic [63:0] r;
    wr(6'h01, 8'h05); wr(6'h02, 8'h04);
    wr(6'h00, 8'h03);
    chk("R4 busy after start", busyO, 1);
    rd(6'h1E, b); chk("R12 status busy", b, 8'h80);
    waitDone(16, "R4 single");
    chk("R9 no irq when disabled", irqO, 0);
    expResp[5] = refBit(6'd5);
    readResp(r); chk("R7 single response", r, expResp);
    rd(6'h1E, b); chk("R12 status done", b, 8'h40);
    chk("R12 low byte pin", respLowO, expResp[7:0]);
    rd(6'h00, b); chk("R2 start self-cleared", b, 8'h01);
  endtask

  task automatic testClamp();
    logic [7:0] b;
    wr(6'h20, 8'h60);
    wr(6'h01, 8'h06); wr(6'h02, 8'h00); wr(6'h00, 8'h03);
    waitDone(16, "R5 exp 0 clamped to 4");
    expResp[6] = refBit(6'd6);
    wr(6'h20, 8'h60);
    wr(6'h01, 8'h09); wr(6'h02, 8'h05); wr(6'h00, 8'h03);
    waitDone(32, "R5 exp 5");
    expResp[9] = refBit(6'd9);
    wr(6'h20, 8'h60);
    wr(6'h01, 8'h0A); wr(6'h02, 8'h0F); wr(6'h00, 8'h03);
    waitDone(4096, "R5 exp 15 clamped to 12");
    expResp[10] = refBit(6'd10);
    rd(6'h1F, b); chk("R6 index single", b, 8'h0A);
  endtask

  task automatic testW1c();
    wr(6'h20, 8'h60);
    wr(6'h00, 8'h81);
    wr(6'h01, 8'h03); wr(6'h02, 8'h04); wr(6'h00, 8'h83);
    waitDone(16, "R9 run");
    expResp[3] = refBit(6'd3);
    chk("R9 irq set with enable", irqO, 1);
    wr(6'h20, 8'h20);
    chk("R10 irq cleared", irqO, 0);
    chk("R10 done kept", doneO, 1);
    wr(6'h20, 8'h40);
    chk("R10 done cleared", doneO, 0);
    wr(6'h00, 8'h01);
  endtask

  task automatic testSweep();
    logic [7:0] b;
    logic [63:0] r;
    int clears = 0;
    int chalErr = 0;
    wr(6'h00, 8'h11);
    expResp = '0;
    readResp(r); chk("R11 resp cleared", r, 0);
    rd(6'h00, b); chk("R11 clear bit self-clears", b, 8'h01);
    wr(6'h03, 8'h08); wr(6'h02, 8'h14); wr(6'h00, 8'h03);
    for (int i = 0; i < 128; i++) begin
      if (i == 49) begin
        rd(6'h1F, b); chk("R6 index mid sweep", b, 3);
      end
      if (genClear) clears++;
      if (genChallenge !== 6'(i / 16)) chalErr++;
      if (i == 127) chk("R6 busy last cycle", busyO, 1);
      @(negedge clk);
    end
    chk("R6 done after 8 windows", doneO, 1);
    chk("R13 clear pulses", clears, 8);
    chk("R13 challenge per window", chalErr, 0);
    for (int c = 0; c < 8; c++) expResp[c] = refBit(6'(c));
    readResp(r); chk("R6 sweep response", r, expResp);
    rd(6'h1F, b); chk("R6 index after sweep", b, 7);
  endtask

  task automatic testFullXor();
    logic [63:0] vecVal = 64'hF0E1_D2C3_B4A5_9687;
    logic [63:0] r;
    wr(6'h20, 8'h60);
    for (int i = 0; i < 8; i++) wr(6'(12 + i), vecVal[i*8 +: 8]);
    wr(6'h03, 8'h40); wr(6'h02, 8'h14);
    wr(6'h00, 8'h1B);
    waitDone(1024, "R6 full sweep");
    for (int c = 0; c < 64; c++) expResp[c] = refBit(6'(c)) ^ vecVal[c];
    readResp(r); chk("R7 folded response", r, expResp);
    chk("R12 low byte folded", respLowO, expResp[7:0]);
    wr(6'h00, 8'h01);
  endtask

  task automatic testMaxClamp();
    logic [7:0] b;
    wr(6'h20, 8'h60);
    wr(6'h03, 8'h00); wr(6'h00, 8'h03);
    waitDone(16, "R6 max 0 acts as 1");
    rd(6'h1F, b); chk("R6 index max 0", b, 0);
    wr(6'h20, 8'h60);
    wr(6'h03, 8'h64); wr(6'h00, 8'h03);
    waitDone(1024, "R6 max 100 acts as 64");
    rd(6'h1F, b); chk("R6 index max 100", b, 63);
  endtask

  task automatic testBusyStart();
    logic [7:0] b;
    wr(6'h20, 8'h60);
    wr(6'h03, 8'h02); wr(6'h02, 8'h14); wr(6'h00, 8'h03);
    waitCycles(20);
    rd(6'h1F, b); chk("R3 index before restart try", b, 1);
    wr(6'h00, 8'h03);
    rd(6'h1F, b); chk("R3 restart ignored index", b, 1);
    waitDone(11, "R3 restart ignored timing");
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testNoStart();
    testSingle();
    testClamp();
    testW1c();
    testSweep();
    testFullXor();
    testMaxClamp();
    testBusyStart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule